// File: doc/BRIEF.md
# Parallel Output Test Pattern Generator

This block sits in front of the parallel output drivers of a data converter. It passes two 12-bit sample buses, A and B, to the outputs unchanged, or it replaces them with a known pattern. A receiver can use the pattern to confirm that its capture timing has closed and that every line of the link carries data correctly. A two-bit mode input picks the source. The mode normally comes from a control register that sits outside this block.

There are two test patterns. The toggle pattern flips every output line between all ones and all zeros on each sample clock. The PRBS pattern produces one pseudo-random bit per clock from a free-running 7-stage shift register with polynomial x^7 + x^6 + 1. That one bit is copied onto every line of both buses. The shift register is never reset or seeded, so the receiver has to lock on by shifting its own copy of the sequence until it matches. In toggle mode, bus B follows bus A in phase or in opposite phase, and a build parameter chooses which.

Every output is registered. A change on any input shows at the outputs after the next rising clock edge.

Top module: `pattern_gen_top`

## Requirements
- R1: While the synchronous active-low reset `rstN` is sampled low at a rising edge, both output buses become all zeros at that edge.
- R2: With mode 2'b00 (normal), `outA` and `outB` equal `dataA` and `dataB` as sampled at the previous rising edge.
- R3: Mode 2'b11 is reserved and behaves exactly as mode 2'b00: the data passes through.
- R4: With mode 2'b01 (toggle), every bit of `outA` is the same, so the word is all ones or all zeros, and the word inverts on every clock while the mode is held.
- R5: In toggle mode, `outB` equals `outA` when parameter `TOGGLE_OPPOSITE` is 0 (the default) and equals its bitwise inverse when the parameter is 1.
- R6: With mode 2'b10 (PRBS), each bus word is all ones or all zeros, and `outB` equals `outA`.
- R7: In PRBS mode, the per-clock bit s[n] shown on the outputs obeys s[n] = s[n-6] XOR s[n-7] during any unbroken run of PRBS output, and it never settles into a constant value.
- R8: The PRBS bit sequence repeats with a period of exactly 127 clocks, and any 127 consecutive bits contain 64 ones.
- R9: A mode change presented before a rising edge changes the source of the outputs at that same edge: one register stage of latency, and no output change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; all registers update on its rising edge |
| rstN | input | 1 | Synchronous active-low reset for the output and toggle registers |
| mode | input | 2 | Source select: 00 data, 01 toggle, 10 PRBS, 11 reserved (data) |
| dataA | input | 12 | Sample word for bus A |
| dataB | input | 12 | Sample word for bus B |
| outA | output | 12 | Registered bus A output |
| outB | output | 12 | Registered bus B output |

## Verification
Pass-through is driven with words that differ between the two buses and cover all zeros, all ones, alternating bits and single set bits. These words show up a swapped bus, a stuck or crossed lane, or a reserved code that is decoded as a pattern. The toggle run is checked for flat words, alternation on every clock and the in-phase relationship between A and B, so a lane that misses the pattern or a bus that is inverted stands out. The PRBS capture runs for two full periods. It is checked against the six-and-seven-back recurrence, the 127-clock repeat and the count of 64 ones, which separates the correct polynomial from wrong taps, a stalled register and the all-zero lockup state. Directed steps test synchronous reset and the one-edge latency of mode switches.

// File: rtl/patgen_pkg.sv
package patgen_pkg;

  typedef enum logic [1:0] {
    MODE_DATA   = 2'b00,
    MODE_TOGGLE = 2'b01,
    MODE_PRBS   = 2'b10,
    MODE_RSVD   = 2'b11
  } patModeE;

  typedef struct packed {
    logic pickData;
    logic pickToggle;
    logic pickPrbs;
  } selStrobesT;

endpackage

// File: rtl/patgen_ctrl.sv
module patgen_ctrl
  import patgen_pkg::*;
(
  input  logic [1:0]  mode,
  output selStrobesT  strb
);

  patModeE modeE;

  always_comb begin
    modeE = patModeE'(mode);
    strb  = '0;
    unique case (modeE)
      MODE_TOGGLE: strb.pickToggle = 1'b1;
      MODE_PRBS:   strb.pickPrbs   = 1'b1;
      MODE_DATA,
      MODE_RSVD:   strb.pickData   = 1'b1;
      default:     strb.pickData   = 1'b1;
    endcase
  end

endmodule

// File: rtl/patgen_lfsr.sv
module patgen_lfsr #(
  parameter int LFSR_LEN = 7,
  parameter int TAP_HI   = 7,
  parameter int TAP_LO   = 6
) (
  input  logic clk,
  output logic bitOut
);

  localparam logic [LFSR_LEN-1:0] RESCUE = {{(LFSR_LEN-1){1'b0}}, 1'b1};

  logic [LFSR_LEN-1:0] state;
  logic [LFSR_LEN-1:0] nextState;
  logic                feedback;

  always_comb begin
    feedback = state[TAP_HI-1] ^ state[TAP_LO-1];
    if (state == '0) nextState = RESCUE;
    else             nextState = {state[LFSR_LEN-2:0], feedback};
  end

  always_ff @(posedge clk) begin
    state <= nextState;
  end

  assign bitOut = state[LFSR_LEN-1];

endmodule

// File: rtl/patgen_datapath.sv
module patgen_datapath
  import patgen_pkg::*;
#(
  parameter int WIDTH           = 12,
  parameter bit TOGGLE_OPPOSITE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  selStrobesT       strb,
  input  logic             prbsBit,
  input  logic [WIDTH-1:0] dataA,
  input  logic [WIDTH-1:0] dataB,
  output logic [WIDTH-1:0] outA,
  output logic [WIDTH-1:0] outB
);

  logic             phase;
  logic             phaseB;
  logic [WIDTH-1:0] nextA;
  logic [WIDTH-1:0] nextB;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= 1'b0;
    else       phase <= ~phase;
  end

  generate
    if (TOGGLE_OPPOSITE) begin : g_phase_inv
      assign phaseB = ~phase;
    end else begin : g_phase_same
      assign phaseB = phase;
    end
  endgenerate

  for (genvar lane = 0; lane < WIDTH; lane++) begin : g_lane
    always_comb begin
      if (strb.pickToggle) begin
        nextA[lane] = phase;
        nextB[lane] = phaseB;
      end else if (strb.pickPrbs) begin
        nextA[lane] = prbsBit;
        nextB[lane] = prbsBit;
      end else begin
        nextA[lane] = dataA[lane];
        nextB[lane] = dataB[lane];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outA <= '0;
      outB <= '0;
    end else begin
      outA <= nextA;
      outB <= nextB;
    end
  end

endmodule

// File: rtl/pattern_gen_top.sv
module pattern_gen_top
  import patgen_pkg::*;
#(
  parameter int WIDTH           = 12,
  parameter int LFSR_LEN        = 7,
  parameter int TAP_HI          = 7,
  parameter int TAP_LO          = 6,
  parameter bit TOGGLE_OPPOSITE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] dataA,
  input  logic [WIDTH-1:0] dataB,
  output logic [WIDTH-1:0] outA,
  output logic [WIDTH-1:0] outB
);

  selStrobesT strb;
  logic       prbsBit;

  patgen_ctrl u_ctrl (
    .mode (mode),
    .strb (strb)
  );

  patgen_lfsr #(
    .LFSR_LEN (LFSR_LEN),
    .TAP_HI   (TAP_HI),
    .TAP_LO   (TAP_LO)
  ) u_lfsr (
    .clk    (clk),
    .bitOut (prbsBit)
  );

  patgen_datapath #(
    .WIDTH           (WIDTH),
    .TOGGLE_OPPOSITE (TOGGLE_OPPOSITE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .prbsBit (prbsBit),
    .dataA   (dataA),
    .dataB   (dataB),
    .outA    (outA),
    .outB    (outB)
  );

endmodule

// File: rtl/pattern_gen_checker.sv
module pattern_gen_checker #(
  parameter int WIDTH           = 12,
  parameter bit TOGGLE_OPPOSITE = 1'b0
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] dataA,
  input logic [WIDTH-1:0] dataB,
  input logic [WIDTH-1:0] outA,
  input logic [WIDTH-1:0] outB
);

  localparam logic [WIDTH-1:0] ONES = '1;

  logic [1:0] modeQ;
  logic       liveQ;
  logic [3:0] prbsRun;
  logic       curPrbs;

  assign curPrbs = liveQ && (modeQ == 2'b10);

  always_ff @(posedge clk) begin
    modeQ <= mode;
    liveQ <= rstN;
    if (curPrbs && rstN) prbsRun <= (prbsRun == 4'd15) ? prbsRun : prbsRun + 4'd1;
    else                 prbsRun <= 4'd0;
  end

  p_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00) |=> (outA == $past(dataA)) && (outB == $past(dataB)));

  p_reserved_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11) |=> (outA == $past(dataA)) && (outB == $past(dataB)));

  p_toggle_flip_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01 && liveQ && modeQ == 2'b01) |=>
      ((outA == '0) || (outA == ONES)) && (outA == ~$past(outA)));

  p_toggle_bus_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01) |=> (outB == (TOGGLE_OPPOSITE ? ~outA : outA)));

  p_prbs_flat_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10) |=> ((outA == '0) || (outA == ONES)) && (outB == outA));

  p_prbs_recur_r7: assert property (@(posedge clk) disable iff (!rstN)
    (curPrbs && prbsRun >= 4'd7) |->
      (outA[0] == ($past(outA[0], 6) ^ $past(outA[0], 7))));

  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    (liveQ && $past(mode) != 2'b00 && mode == 2'b00) |=> (outA == $past(dataA)));

endmodule

bind pattern_gen_top pattern_gen_checker #(
  .WIDTH           (WIDTH),
  .TOGGLE_OPPOSITE (TOGGLE_OPPOSITE)
) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .mode  (mode),
  .dataA (dataA),
  .dataB (dataB),
  .outA  (outA),
  .outB  (outB)
);

// File: tb/pattern_gen_top_tb.sv
`timescale 1ns/1ps
module pattern_gen_top_tb;

  localparam int W = 12;
  localparam int NV = 8;
  localparam int NP = 254;

  // {mode, dataA, dataB}
  localparam logic [25:0] VEC [NV] = '{
    {2'b00, 12'h000, 12'hFFF},
    {2'b00, 12'hFFF, 12'h000},
    {2'b00, 12'hAAA, 12'h555},
    {2'b11, 12'h555, 12'hAAA},
    {2'b00, 12'h001, 12'h800},
    {2'b11, 12'h800, 12'h001},
    {2'b00, 12'h3C5, 12'hC3A},
    {2'b11, 12'h123, 12'h456}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] dataA = '0;
  logic [W-1:0] dataB = '0;
  logic [W-1:0] outA;
  logic [W-1:0] outB;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  bit seq [NP];

  always #5 clk = ~clk;

  pattern_gen_top u_dut (
    .clk   (clk),
    .rstN  (rstN),
    .mode  (mode),
    .dataA (dataA),
    .dataB (dataB),
    .outA  (outA),
    .outB  (outB)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit flat(input logic [W-1:0] v);
    return (v == '0) || (v == '1);
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] prevA;
    int ones;
    bit recurOk, periodOk;

    // R1: reset state
    dataA = 12'hABC; dataB = 12'hDEF;
    repeat (3) @(negedge clk);
    check(outA == '0 && outB == '0, "R1 reset", {outA, outB}, 0);
    rstN = 1'b1;

    // R2/R3: vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode  = VEC[i][25:24];
      dataA = VEC[i][23:12];
      dataB = VEC[i][11:0];
      @(negedge clk);
      check(outA == VEC[i][23:12] && outB == VEC[i][11:0],
            (VEC[i][25:24] == 2'b11) ? "R3 reserved pass" : "R2 pass",
            {outA, outB}, VEC[i][23:0]);
    end

    // R9: switch to toggle, no change before the edge, change after
    dataA = 12'h5A5; dataB = 12'h5A5;
    @(negedge clk);
    mode = 2'b01;
    #2;
    check(outA == 12'h5A5, "R9 no change before edge", outA, 12'h5A5);
    @(negedge clk);
    check(flat(outA), "R9 toggle after one edge", outA, 0);

    // R4/R5: toggle alternation and bus relation
    prevA = outA;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(flat(outA) && outA == ~prevA, "R4 toggle flip", outA, ~prevA);
      check(outB == outA, "R5 toggle bus B in phase", outB, outA);
      prevA = outA;
    end

    // R9: back to data, visible after one edge
    mode = 2'b00; dataA = 12'h123; dataB = 12'h321;
    @(negedge clk);
    check(outA == 12'h123 && outB == 12'h321, "R9 back to data", {outA, outB}, {12'h123, 12'h321});

    // R6/R7/R8: PRBS capture
    mode = 2'b10;
    @(negedge clk);
    for (int n = 0; n < NP; n++) begin
      @(negedge clk);
      check(flat(outA) && outB == outA, "R6 prbs flat and equal", {outA, outB}, {outA, outA});
      seq[n] = outA[0];
    end
    recurOk = 1'b1;
    for (int n = 7; n < NP; n++)
      if (seq[n] != (seq[n-6] ^ seq[n-7])) recurOk = 1'b0;
    check(recurOk, "R7 prbs recurrence", recurOk, 1);
    periodOk = 1'b1;
    for (int n = 127; n < NP; n++)
      if (seq[n] != seq[n-127]) periodOk = 1'b0;
    check(periodOk, "R8 prbs period 127", periodOk, 1);
    ones = 0;
    for (int n = 0; n < 127; n++) ones += int'(seq[n]);
    check(ones == 64, "R8 ones per period", ones, 64);
    check(ones != 0 && ones != 127, "R7 prbs not constant", ones, 64);

    // R1: synchronous reset mid-run
    mode = 2'b00; dataA = 12'hFFF; dataB = 12'hFFF;
    @(negedge clk);
    check(outA == 12'hFFF, "R2 pass before reset", outA, 12'hFFF);
    rstN = 1'b0;
    #2;
    check(outA == 12'hFFF, "R1 reset is synchronous", outA, 12'hFFF);
    @(negedge clk);
    check(outA == '0 && outB == '0, "R1 reset clears", {outA, outB}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outA == 12'hFFF, "R2 pass after reset", outA, 12'hFFF);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule